// File: doc/BRIEF.md
# Half-Rate Two-Stage Parallel Serializer

This block turns a parallel word into a single serial bit stream. It uses a clock that runs at half the bit rate. The word is split into two lanes. Even-indexed bits go to lane 0 and odd-indexed bits go to lane 1. Each lane is a shift register of length N. A final 2:1 stage merges the two lanes: the lane-0 bit drives the output while the clock is high, and the lane-1 bit drives it while the clock is low. So two bits leave in every clock cycle. Because the first stage can have any length N, every even ratio 2N is available, not only powers of two.

A front stage can be enabled with parameter M greater than 1. It accepts a word of 2·N·M bits and hands it to the lanes in M chunks of 2N bits each, lowest chunk first. The block drives a load strobe that tells the upstream logic when to present the next word. The word is sampled on the rising edge that ends a strobe cycle. Consecutive words stream out with no gap between them.

Top module: `halfrate_serializer`

## Requirements
- R1: Word bit 0 is transmitted first, and word bit i occupies position i of that word's serial slot. With M greater than 1, chunk c consists of bits 2N·c to 2N·c+2N-1.
- R2: Each clock cycle carries two bits. The even-indexed bit is on `serOut` while `clk` is high, and the odd-indexed bit is on `serOut` while `clk` is low that same cycle.
- R3: `loadStrobe` is high for exactly one cycle in every N·M cycles. The word is sampled on the rising edge that ends a strobe cycle.
- R4: `loadStrobe` is high in the first cycle after reset is released.
- R5: `serOut` is 0 while `rst` is high. After reset it stays 0 until the high phase that begins one rising edge after the first word is sampled. Bit 0 appears in that high phase.
- R6: Consecutive words follow each other with no idle bit and no repeated bit.
- R7: A lane load that starts a new word always coincides with a lane load. Changes on `word` outside the sampling edge have no effect on the stream.
- R8: Any N ≥ 1 and any M ≥ 1 are supported, and the same bit order holds for each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock; both phases carry a bit |
| rst | input | 1 | Asynchronous reset, active high |
| word | input | 2·N·M | Parallel word, sampled on the edge that ends a strobe cycle |
| serOut | output | 1 | Serial bit stream, two bits per clock cycle |
| loadStrobe | output | 1 | High for one cycle when the next word must be present |

## Verification
Bit 0 of a word sampled at rising edge P0 is due 2.5 ns into the high phase after edge P0+1. Bit 1 is due in the following low phase, and the stream then continues two bits per cycle. The monitor samples each phase 2.5 ns after its edge and pops one expected bit per phase, so the comparison is always against that fixed latency. Before the first bit is due, it expects 0. The driver samples the strobe 1 ns after the falling edge, counts the cycles between strobes, and writes a fresh word there. On every other falling edge it writes a random junk word that must never reach the output.

// File: rtl/halfrate_ser_pkg.sv
package halfrate_ser_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadLanes;  // lanes take a fresh 2N-bit chunk at the next rising edge
    logic loadWord;   // the chunk comes straight from the input word
  } serStrobe_t;

  function automatic int cntWidth(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/hrs_control.sv
module hrs_control
  import halfrate_ser_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 1
) (
  input  logic       clk,
  input  logic       rst,
  output serStrobe_t strobes
);

  localparam int BIT_W   = cntWidth(N);
  localparam int CHUNK_W = cntWidth(M);

  logic [BIT_W-1:0]   bitCnt;
  logic [CHUNK_W-1:0] chunkCnt;
  logic               lastBit;
  logic               lastChunk;

  assign lastBit   = (bitCnt == BIT_W'(N - 1));
  assign lastChunk = (chunkCnt == CHUNK_W'(M - 1));

  // Reset to the final position so the first cycle after reset is a load cycle
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bitCnt   <= BIT_W'(N - 1);
      chunkCnt <= CHUNK_W'(M - 1);
    end else begin
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (lastBit) chunkCnt <= lastChunk ? '0 : chunkCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.loadLanes = lastBit;
    strobes.loadWord  = lastBit && lastChunk;
  end

endmodule

// File: rtl/hrs_datapath.sv
module hrs_datapath
  import halfrate_ser_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  serStrobe_t       strobes,
  input  logic [2*N*M-1:0] word,
  output logic             serOut
);

  localparam int WORD_W  = 2 * N * M;
  localparam int CHUNK_W = 2 * N;

  logic [CHUNK_W-1:0] nextChunk;
  logic [N-1:0]       evenIn, oddIn;
  logic [N-1:0]       lane0Reg, lane1Reg;
  logic               hiBit, pendLo, loBit;

  // Optional front stage: holds the upper chunks of a wide word
  generate
    if (M > 1) begin : g_front
      localparam int HOLD_W = WORD_W - CHUNK_W;
      logic [HOLD_W-1:0] holdReg;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)                    holdReg <= '0;
        else if (strobes.loadWord)  holdReg <= word[WORD_W-1:CHUNK_W];
        else if (strobes.loadLanes) holdReg <= holdReg >> CHUNK_W;
      end
      assign nextChunk = strobes.loadWord ? word[CHUNK_W-1:0] : holdReg[CHUNK_W-1:0];
    end else begin : g_direct
      assign nextChunk = word;
    end
  endgenerate

  // Even bits feed lane 0, odd bits feed lane 1
  generate
    for (genvar i = 0; i < N; i++) begin : g_split
      assign evenIn[i] = nextChunk[2*i];
      assign oddIn[i]  = nextChunk[2*i+1];
    end
  endgenerate

  // N:1 stage, one shift register per lane
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lane0Reg <= '0;
      lane1Reg <= '0;
    end else if (strobes.loadLanes) begin
      lane0Reg <= evenIn;
      lane1Reg <= oddIn;
    end else begin
      lane0Reg <= lane0Reg >> 1;
      lane1Reg <= lane1Reg >> 1;
    end
  end

  // 2:1 stage: the lane-0 bit is taken on the rising edge; the lane-1 bit is staged
  // then and moved on the falling edge
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hiBit  <= 1'b0;
      pendLo <= 1'b0;
    end else begin
      hiBit  <= lane0Reg[0];
      pendLo <= lane1Reg[0];
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) loBit <= 1'b0;
    else     loBit <= pendLo;
  end

  assign serOut = clk ? hiBit : loBit;

endmodule

// File: rtl/halfrate_serializer.sv
module halfrate_serializer
  import halfrate_ser_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2*N*M-1:0] word,
  output logic             serOut,
  output logic             loadStrobe
);

  serStrobe_t strobes;

  hrs_control #(.N(N), .M(M)) u_control (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  hrs_datapath #(.N(N), .M(M)) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .word    (word),
    .serOut  (serOut)
  );

  assign loadStrobe = strobes.loadWord;

endmodule

// File: rtl/halfrate_serializer_chk.sv
module halfrate_serializer_chk
  import halfrate_ser_pkg::*;
#(
  parameter int N = 4,
  parameter int M = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       loadStrobe,
  input logic       serOut,
  input serStrobe_t strobes
);

  localparam int K = N * M;

  logic [31:0] gapCnt;
  logic        loaded;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             gapCnt <= 32'(K - 1);
    else if (loadStrobe) gapCnt <= '0;
    else                 gapCnt <= gapCnt + 1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             loaded <= 1'b0;
    else if (loadStrobe) loaded <= 1'b1;
  end

  // R3, and R4 through the reset value of gapCnt
  assert_strobe_period_R3: assert property (@(posedge clk) disable iff (rst)
    loadStrobe == (gapCnt == 32'(K - 1)));

  generate
    if (K > 1) begin : g_single
      assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        loadStrobe |=> !loadStrobe);
    end
  endgenerate

  assert_quiet_until_load_R5: assert property (@(negedge clk) disable iff (rst)
    !loaded |-> !serOut);

  assert_word_on_lane_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.loadWord |-> strobes.loadLanes);

endmodule

bind halfrate_serializer halfrate_serializer_chk #(.N(N), .M(M)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .loadStrobe (loadStrobe),
  .serOut     (serOut),
  .strobes    (strobes)
);

// File: tb/tb_halfrate_serializer.sv
`timescale 1ns/1ps

module tb_hrs_unit #(
  parameter int N = 2,
  parameter int M = 1,
  parameter int WORDS = 20
) (
  input logic clk
);

  localparam int K = N * M;
  localparam int W = 2 * N * M;

  logic         rst = 1'b1;
  logic [W-1:0] word = '0;
  logic         serOut, loadStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit expQ[$];
  int pushes = 0;
  int compared = 0;
  bit loadSeen = 0;
  bit streaming = 0;

  halfrate_serializer #(.N(N), .M(M)) dut (
    .clk        (clk),
    .rst        (rst),
    .word       (word),
    .serOut     (serOut),
    .loadStrobe (loadStrobe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (N=%0d M=%0d) actual=%0d expected=%0d", req, N, M, act, exp);
    end
  endtask

  // Driver: a fresh word on each strobe, junk at other times (R7)
  initial begin
    int gap;
    bit first;
    gap = 0;
    first = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    while (!done) begin
      #1;
      gap++;
      if (loadStrobe) begin
        if (first) chk(gap == 1, "R4 first strobe", gap, 1);
        else       chk(gap == K, "R3 strobe spacing", gap, K);
        first = 0;
        gap = 0;
        word = W'($urandom);
        if (pushes < WORDS) begin
          for (int b = 0; b < W; b++) expQ.push_back(word[b]);  // R1 order, R6 back to back
          pushes++;
        end
      end else begin
        word = W'($urandom);  // R7: must not affect the stream
      end
      @(negedge clk);
    end
  end

  task automatic samplePhase(input string req);
    bit exp;
    if (done) return;
    if (streaming) begin
      exp = expQ.pop_front();
      chk(serOut == exp, req, int'(serOut), int'(exp));
      compared++;
      if (compared == WORDS * W) done = 1;
    end else begin
      chk(serOut == 1'b0, "R5 quiet output", int'(serOut), 0);
    end
  endtask

  // Monitor: bit 0 is due in the high phase one rising edge after the load edge
  initial begin
    forever begin
      @(posedge clk);
      if (loadSeen) streaming = 1;
      if (pushes > 0) loadSeen = 1;
      #2.5;
      samplePhase("R1 R2 R6 R7 R8 high-phase bit");
      @(negedge clk);
      #2.5;
      samplePhase("R1 R2 R6 R7 R8 low-phase bit");
    end
  end

endmodule

module tb_halfrate_serializer;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  tb_hrs_unit #(.N(1), .M(1), .WORDS(40)) u_n1 (.clk(clk));
  tb_hrs_unit #(.N(3), .M(1), .WORDS(30)) u_n3 (.clk(clk));
  tb_hrs_unit #(.N(5), .M(1), .WORDS(30)) u_n5 (.clk(clk));
  tb_hrs_unit #(.N(2), .M(3), .WORDS(30)) u_n2m3 (.clk(clk));

  initial begin
    int cyc;
    int checks;
    int errors;
    cyc = 0;
    while (!(u_n1.done && u_n3.done && u_n5.done && u_n2m3.done) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    checks = u_n1.checks + u_n3.checks + u_n5.checks + u_n2m3.checks;
    errors = u_n1.errors + u_n3.errors + u_n5.errors + u_n2m3.errors;
    if (cyc >= 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=%0d expected<%0d cycles", cyc, 20000);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule